// File: doc/BRIEF.md
# External Bus Address and Chip-Select Sequencer

This block drives the pins of a separated external bus: address, four active-low chip selects, active-low read and write strobes, the write data and its output enable. It has no wait states. In every bus-clock cycle the core offers at most one request, made of a valid flag, an address, a write flag and write data. The block decides whether the request targets one of the external chip-select regions, the internal memory space, or nothing. It registers the resulting pin state on the next rising edge, so each access takes exactly one bus cycle.

The pin state is chosen cycle by cycle so the pins toggle as little as possible. The address bus moves only when an external access is made. A chip select moves only when the target region changes or an internal access arrives. Back-to-back accesses to one region keep its chip select low with no gap. An idle cycle freezes both the address and the chip selects, so a chip select can stay low for many cycles in a row. The strobes and the data output enable are active only in external access cycles. The pad ring uses `data_oe_o` to tri-state the data pins.

Top module: `ext_bus_seq`

## Requirements
- R1: While rst_ni is low, addr_o is 0, every cs_no bit is 1, rd_no and wr_no are 1, and data_oe_o is 0.
- R2: A valid request whose address lies in region k asserts only cs_no[k] low and places the address on addr_o, one clock edge after the request is sampled. With the default parameters the regions are: k=0 covers 0x40000..0x4FFFF, k=1 covers 0x50000..0x5FFFF, k=2 covers 0x60000..0x7FFFF, and k=3 covers 0x80000..0xFFFFF.
- R3: An external access to region j that follows an external access to a different region i changes both the address and the chip selects in the same edge: cs_no[i] rises and cs_no[j] falls.
- R4: A valid request that hits no external region is an internal access. All chip selects go high, and addr_o keeps the previous value.
- R5: Consecutive external accesses to one region keep that chip select low through both cycles, while addr_o takes the new address.
- R6: A cycle with req_valid_i low leaves addr_o and cs_no unchanged.
- R7: rd_no is low only after an external read (req_we_i=0), and wr_no is low only after an external write (req_we_i=1). Both strobes are high after internal or idle cycles.
- R8: data_oe_o is 1 only after an external write, and data_o then carries that write's data.
- R9: At most one cs_no bit is low in any cycle.
- R10: Through a run of same-region accesses and idle cycles, a chip select stays low for more than two consecutive cycles.
- R11: The region bounds are inclusive: a region's first and last address select it, and address 0x3FFFF is internal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Core requests an access this cycle |
| req_addr_i | input | 20 | Request address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 16 | Write data |
| addr_o | output | 20 | External address bus |
| cs_no | output | 4 | Active-low chip selects, one per region |
| rd_no | output | 1 | Active-low read strobe |
| wr_no | output | 1 | Active-low write strobe |
| data_o | output | 16 | Write data toward the data pins |
| data_oe_o | output | 1 | Data pin output enable, 1 = drive |

## Verification
The assertions check on every cycle the following rules: only one chip select is low at a time, idle cycles freeze the address and chip selects, internal accesses release every chip select and hold the address, and the strobe and output-enable rules follow the previous request. Only the bench scenarios can show the rest. These are the reset values, the exact region boundaries, chip selects held low across runs longer than two cycles, and the four transition cases in sequence, driven by mixed random and directed requests.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_INT  = 2'd1,
    ACC_EXT  = 2'd2
  } acc_kind_e;

  localparam int unsigned DEF_ADDR_W = 20;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_NUM_CS = 4;
endpackage

// File: rtl/ext_bus_region_dec.sv
module ext_bus_region_dec
  import ext_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned NUM_CS = 4,
  parameter logic [NUM_CS-1:0][ADDR_W-1:0] CS_BASE = '0,
  parameter logic [NUM_CS-1:0][ADDR_W-1:0] CS_LAST = '0
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [NUM_CS-1:0] hit_oh_o
);
  logic [NUM_CS-1:0] hit_raw;

  for (genvar k = 0; k < NUM_CS; k++) begin : g_range
    assign hit_raw[k] = (addr_i >= CS_BASE[k]) && (addr_i <= CS_LAST[k]);
  end

  // lowest index wins if ranges overlap
  always_comb begin
    hit_oh_o = '0;
    for (int k = NUM_CS - 1; k >= 0; k--) begin
      if (hit_raw[k]) hit_oh_o = NUM_CS'(1) << k;
    end
  end

  always_comb begin
    if (!valid_i)      kind_o = ACC_IDLE;
    else if (|hit_raw) kind_o = ACC_EXT;
    else               kind_o = ACC_INT;
  end
endmodule

// File: rtl/ext_bus_pin_ctl.sv
module ext_bus_pin_ctl
  import ext_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_CS = 4
) (
  input  acc_kind_e         kind_i,
  input  logic [NUM_CS-1:0] hit_oh_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [NUM_CS-1:0] cur_cs_ni,
  input  logic [DATA_W-1:0] cur_data_i,
  output logic [ADDR_W-1:0] nxt_addr_o,
  output logic [NUM_CS-1:0] nxt_cs_no,
  output logic              nxt_rd_no,
  output logic              nxt_wr_no,
  output logic [DATA_W-1:0] nxt_data_o,
  output logic              nxt_oe_o
);
  always_comb begin
    nxt_addr_o = cur_addr_i;
    nxt_cs_no  = cur_cs_ni;
    nxt_rd_no  = 1'b1;
    nxt_wr_no  = 1'b1;
    nxt_oe_o   = 1'b0;
    nxt_data_o = cur_data_i;
    unique case (kind_i)
      ACC_EXT: begin
        nxt_addr_o = req_addr_i;
        nxt_cs_no  = ~hit_oh_i;
        nxt_rd_no  = req_we_i;
        nxt_wr_no  = ~req_we_i;
        nxt_oe_o   = req_we_i;
        if (req_we_i) nxt_data_o = req_wdata_i;
      end
      ACC_INT: nxt_cs_no = '1;  // address pins keep the last external value
      default: ;                // idle: address and selects frozen
    endcase
  end
endmodule

// File: rtl/ext_bus_pin_reg.sv
module ext_bus_pin_reg #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_CS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] nxt_addr_i,
  input  logic [NUM_CS-1:0] nxt_cs_ni,
  input  logic              nxt_rd_ni,
  input  logic              nxt_wr_ni,
  input  logic [DATA_W-1:0] nxt_data_i,
  input  logic              nxt_oe_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [NUM_CS-1:0] cs_nq_o,
  output logic              rd_nq_o,
  output logic              wr_nq_o,
  output logic [DATA_W-1:0] data_q_o,
  output logic              oe_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o <= '0;
      cs_nq_o  <= '1;
      rd_nq_o  <= 1'b1;
      wr_nq_o  <= 1'b1;
      data_q_o <= '0;
      oe_q_o   <= 1'b0;
    end else begin
      addr_q_o <= nxt_addr_i;
      cs_nq_o  <= nxt_cs_ni;
      rd_nq_o  <= nxt_rd_ni;
      wr_nq_o  <= nxt_wr_ni;
      data_q_o <= nxt_data_i;
      oe_q_o   <= nxt_oe_i;
    end
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ext_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned NUM_CS = DEF_NUM_CS,
  parameter logic [NUM_CS-1:0][ADDR_W-1:0] CS_BASE =
    {20'h80000, 20'h60000, 20'h50000, 20'h40000},
  parameter logic [NUM_CS-1:0][ADDR_W-1:0] CS_LAST =
    {20'hFFFFF, 20'h7FFFF, 20'h5FFFF, 20'h4FFFF}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [NUM_CS-1:0] cs_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  acc_kind_e         kind;
  logic [NUM_CS-1:0] hit_oh;
  logic [ADDR_W-1:0] nxt_addr;
  logic [NUM_CS-1:0] nxt_cs_n;
  logic              nxt_rd_n, nxt_wr_n, nxt_oe;
  logic [DATA_W-1:0] nxt_data;

  ext_bus_region_dec #(
    .ADDR_W (ADDR_W), .NUM_CS (NUM_CS),
    .CS_BASE(CS_BASE), .CS_LAST(CS_LAST)
  ) u_dec (
    .valid_i (req_valid_i),
    .addr_i  (req_addr_i),
    .kind_o  (kind),
    .hit_oh_o(hit_oh)
  );

  ext_bus_pin_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS)
  ) u_ctl (
    .kind_i     (kind),
    .hit_oh_i   (hit_oh),
    .req_addr_i (req_addr_i),
    .req_we_i   (req_we_i),
    .req_wdata_i(req_wdata_i),
    .cur_addr_i (addr_o),
    .cur_cs_ni  (cs_no),
    .cur_data_i (data_o),
    .nxt_addr_o (nxt_addr),
    .nxt_cs_no  (nxt_cs_n),
    .nxt_rd_no  (nxt_rd_n),
    .nxt_wr_no  (nxt_wr_n),
    .nxt_data_o (nxt_data),
    .nxt_oe_o   (nxt_oe)
  );

  ext_bus_pin_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS)
  ) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nxt_addr_i(nxt_addr),
    .nxt_cs_ni (nxt_cs_n),
    .nxt_rd_ni (nxt_rd_n),
    .nxt_wr_ni (nxt_wr_n),
    .nxt_data_i(nxt_data),
    .nxt_oe_i  (nxt_oe),
    .addr_q_o  (addr_o),
    .cs_nq_o   (cs_no),
    .rd_nq_o   (rd_no),
    .wr_nq_o   (wr_no),
    .data_q_o  (data_o),
    .oe_q_o    (data_oe_o)
  );
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_CS = 4,
  parameter logic [NUM_CS-1:0][ADDR_W-1:0] CS_BASE = '0,
  parameter logic [NUM_CS-1:0][ADDR_W-1:0] CS_LAST = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_we_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [NUM_CS-1:0] cs_no,
  input logic              rd_no,
  input logic              wr_no,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o
);
  logic              seen;
  logic              ext_hit;

  always_comb begin
    ext_hit = 1'b0;
    for (int k = 0; k < NUM_CS; k++)
      if (req_addr_i >= CS_BASE[k] && req_addr_i <= CS_LAST[k]) ext_hit = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  // R9
  one_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> $onehot0(~cs_no));

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && !req_valid_i |=> $stable(addr_o) && $stable(cs_no));

  // R4
  int_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && req_valid_i && !ext_hit |=> (&cs_no) && $stable(addr_o));

  // R2
  ext_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && req_valid_i && ext_hit |=> addr_o == $past(req_addr_i) && !(&cs_no));

  // R7
  strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && !(req_valid_i && ext_hit) |=> rd_no && wr_no);

  // R7
  wr_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && req_valid_i && ext_hit && req_we_i |=> !wr_no && rd_no);

  // R8
  oe_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && req_valid_i && ext_hit && req_we_i |=> data_oe_o && data_o == $past(req_wdata_i));

  // R8
  oe_only_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && !(req_valid_i && ext_hit && req_we_i) |=> !data_oe_o);
endmodule

bind ext_bus_seq ext_bus_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS),
  .CS_BASE(CS_BASE), .CS_LAST(CS_LAST)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_addr_i (req_addr_i),
  .req_we_i   (req_we_i),
  .req_wdata_i(req_wdata_i),
  .addr_o     (addr_o),
  .cs_no      (cs_no),
  .rd_no      (rd_no),
  .wr_no      (wr_no),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o)
);

// File: tb/ext_bus_seq_tb.sv
`timescale 1ns/1ps
module ext_bus_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v = 1'b0;
  logic [19:0] a = '0;
  logic        we = 1'b0;
  logic [15:0] wd = '0;
  logic [19:0] addr_o;
  logic [3:0]  cs_no;
  logic        rd_no, wr_no, data_oe_o;
  logic [15:0] data_o;

  int checks = 0, fails = 0;
  logic [19:0] e_addr = '0;
  int          e_cs = -1;
  logic        e_rd = 1'b1, e_wr = 1'b1, e_oe = 1'b0;
  logic [15:0] e_data = '0;

  always #2 clk = ~clk;

  ext_bus_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v), .req_addr_i(a),
    .req_we_i(we), .req_wdata_i(wd), .addr_o(addr_o), .cs_no(cs_no),
    .rd_no(rd_no), .wr_no(wr_no), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  function automatic int region(logic [19:0] ad);
    if (ad >= 20'h40000 && ad <= 20'h4FFFF) return 0;
    if (ad >= 20'h50000 && ad <= 20'h5FFFF) return 1;
    if (ad >= 20'h60000 && ad <= 20'h7FFFF) return 2;
    if (ad >= 20'h80000) return 3;
    return -1;
  endfunction

  function automatic logic [3:0] cs_vec(int r);
    logic [3:0] x = 4'hF;
    if (r >= 0) x[r] = 1'b0;
    return x;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit vv, logic [19:0] aa, bit ww, logic [15:0] dd, string tag_in);
    int r;
    string tag;
    r = region(aa);
    if (!vv)             tag = "R6";
    else if (r < 0)      tag = "R4";
    else if (r == e_cs)  tag = "R5";
    else if (e_cs >= 0)  tag = "R3";
    else                 tag = "R2";
    if (tag_in != "") tag = tag_in;
    v = vv; a = aa; we = ww; wd = dd;
    e_rd = 1'b1; e_wr = 1'b1; e_oe = 1'b0;
    if (vv && r >= 0) begin
      e_addr = aa; e_cs = r; e_rd = ww; e_wr = !ww; e_oe = ww;
      if (ww) e_data = dd;
    end else if (vv) begin
      e_cs = -1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(addr_o == e_addr, tag, "addr", 32'(addr_o), 32'(e_addr));
    chk(cs_no == cs_vec(e_cs), tag, "cs", 32'(cs_no), 32'(cs_vec(e_cs)));
    chk(rd_no == e_rd && wr_no == e_wr, "R7", "rd/wr", {30'd0, rd_no, wr_no}, {30'd0, e_rd, e_wr});
    chk(data_oe_o == e_oe && (!e_oe || data_o == e_data), "R8", "oe/data",
        {15'd0, data_oe_o, data_o}, {15'd0, e_oe, e_data});
    chk($countones(~cs_no) <= 1, "R9", "onehot", 32'(cs_no), 32'(cs_vec(e_cs)));
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int run;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(addr_o == '0 && cs_no == 4'hF && rd_no && wr_no && !data_oe_o, "R1", "reset",
        {addr_o, cs_no, rd_no, wr_no, data_oe_o, 5'd0}, {20'd0, 4'hF, 1'b1, 1'b1, 1'b0, 5'd0});
    rst_n = 1'b1;
    @(negedge clk);

    // directed: the four transition cases
    step(1, 20'h41234, 0, 16'h0, "");      // R2 first select
    step(1, 20'h48888, 1, 16'hA5A5, "");   // R5 same region
    step(1, 20'h61000, 0, 16'h0, "");      // R3 other region
    step(1, 20'h01000, 0, 16'h0, "");      // R4 internal
    step(0, 20'h7FFFF, 1, 16'h1111, "");   // R6 idle after internal
    step(1, 20'h90000, 1, 16'h3C3C, "");
    step(0, 20'h00000, 0, 16'h0, "");      // R6 idle keeps cs3

    // R11 boundaries
    step(1, 20'h3FFFF, 0, 16'h0, "R11");
    step(1, 20'h40000, 0, 16'h0, "R11");
    step(1, 20'h4FFFF, 0, 16'h0, "R11");
    step(1, 20'h50000, 0, 16'h0, "R11");
    step(1, 20'h5FFFF, 0, 16'h0, "R11");
    step(1, 20'h60000, 0, 16'h0, "R11");
    step(1, 20'h7FFFF, 0, 16'h0, "R11");
    step(1, 20'h80000, 0, 16'h0, "R11");
    step(1, 20'hFFFFF, 1, 16'hBEEF, "R11");

    // R10 long chip-select run
    run = 0;
    step(1, 20'h52000, 0, 16'h0, "R10");
    if (cs_no[1] == 1'b0) run++;
    step(1, 20'h53000, 1, 16'h7777, "R10");
    if (cs_no[1] == 1'b0) run++;
    step(0, 20'h00000, 0, 16'h0, "R10");
    if (cs_no[1] == 1'b0) run++;
    step(1, 20'h5FFF0, 0, 16'h0, "R10");
    if (cs_no[1] == 1'b0) run++;
    chk(run == 4, "R10", "cs1 low cycles", 32'(run), 32'd4);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int z;
      logic [19:0] ra;
      z = int'($urandom % 6);
      case (z)
        0: ra = 20'h40000 + 20'($urandom % 32'h10000);
        1: ra = 20'h50000 + 20'($urandom % 32'h10000);
        2: ra = 20'h60000 + 20'($urandom % 32'h20000);
        3: ra = 20'h80000 + 20'($urandom % 32'h80000);
        default: ra = 20'($urandom % 32'h40000);
      endcase
      step(($urandom % 5) != 0, ra, $urandom % 2 == 1, 16'($urandom), "");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule